// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. It is built from a square grid of one-bit cells. Each cell ANDs one bit of the multiplicand with one bit of the multiplier and adds that to a sum bit and a carry bit that come in from the row above. Each row handles one multiplier bit. Inside a row, carries are not rippled sideways. Instead, every carry is handed down to the next row at its own weight, and a register bank sits between consecutive rows. A registered carry-propagate adder of `WIDTH` bits turns the last sum and carry vectors into the upper half of the product.

Each row retires exactly one low product bit. That bit then rides along in the pipeline registers, so all product bits leave together. A valid flag travels in step with the data. A new operand pair can be accepted on every clock, and results come out in order after a fixed latency of `WIDTH+1` clock edges.

Top module: `csa_array_mult`

## Requirements
- R1: When `out_valid` is 1, `out_prod` equals the unsigned product `in_a * in_b` of the pair that produced it, as a `2*WIDTH`-bit value with no truncation.
- R2: A pair sampled with `in_valid`=1 at a rising edge shows up on `out_prod` with `out_valid`=1 right after the `WIDTH+1`-th following rising edge, counting the sampling edge as the first.
- R3: Pairs presented on consecutive cycles are all accepted with no stall. Their products come out on consecutive cycles, in the order the pairs were presented, and none is lost.
- R4: An operand slot with `in_valid`=0 produces no result: `out_valid` stays 0 in the matching output slot, whatever data is on `in_a` and `in_b`.
- R5: Reset is synchronous and active low on `rst_n`. An edge that samples `rst_n`=0 clears every in-flight valid flag, so `out_valid` is 0 after it. No pair accepted before the reset ever produces an output.
- R6: After row r, the saved sum vector plus the saved carry vector, weighted by 2^(r+1), plus the retired low product bits r..0, equals `in_a` times bits r..0 of `in_b`. This holds even with all-ones operands, where every carry is set.
- R7: Row r fixes product bit r. Product bits above the current row stay zero in the delay path until their own row fills them. A multiplier with one bit set therefore yields the shifted multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_a`/`in_b` as an operand pair to multiply |
| in_a | input | WIDTH | Unsigned multiplicand |
| in_b | input | WIDTH | Unsigned multiplier; bit r drives row r |
| out_valid | output | 1 | Marks `out_prod` as a finished product |
| out_prod | output | 2*WIDTH | Unsigned product |

## Verification
The bench feeds every one of the 65536 operand pairs of the 8-bit configuration back to back. This catches a mis-weighted carry hand-off, which would corrupt only those products where a carry crosses a column, and a dropped top carry, which shows up first on all-ones operands. Single-bit multipliers expose a low product bit retired into the wrong delay slot, because the product would then come out shifted. A second run leaves random gaps in `in_valid` and drives junk data in the gaps, so a valid flag that slips a stage shows up as a late, early or phantom result. A reset in the middle of traffic must swallow every pair in flight: a design that clears only the data and not the flags would emit stale products afterwards.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

    // Three-input one-bit adder: returns {carry, sum}.
    function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell
    import csa_mult_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  logic sum_in,
    input  logic cry_in,
    output logic sum_out,
    output logic cry_out
);
    logic pp;

    // Partial-product bit folded into a full add with the incoming sum and carry.
    assign pp = a_bit & b_bit;
    assign {cry_out, sum_out} = fa3(pp, sum_in, cry_in);
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int WIDTH = 8,
    parameter int ROW   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic [WIDTH-1:0] cry_i,
    input  logic [WIDTH-1:0] lo_i,
    output logic             v_o,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] cry_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW = 2 * WIDTH + 1;
    localparam logic [WIDTH-1:0] LOW_MASK = {WIDTH{1'b1}} >> (WIDTH - 1 - ROW);

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] s;
        logic [WIDTH-1:0] c;
        logic [WIDTH-1:0] lo;
    } row_st_t;

    row_st_t st_d, st_q;
    logic [WIDTH-1:0] cell_s, cell_c;

    for (genvar j = 0; j < WIDTH; j++) begin : g_cell
        csa_cell u_cell (
            .a_bit  (a_i[j]),
            .b_bit  (b_i[ROW]),
            .sum_in (sum_i[j]),
            .cry_in (cry_i[j]),
            .sum_out(cell_s[j]),
            .cry_out(cell_c[j])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.v    = v_i;
        st_d.a    = a_i;
        st_d.b    = b_i;
        // Sum bit 0 is final; the rest move down one weight for the next row.
        st_d.s    = {1'b0, cell_s[WIDTH-1:1]};
        // Carries already sit one weight up, matching the next row's columns.
        st_d.c    = cell_c;
        st_d.lo   = lo_i;
        st_d.lo[ROW] = cell_s[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o   = st_q.v;
    assign a_o   = st_q.a;
    assign b_o   = st_q.b;
    assign sum_o = st_q.s;
    assign cry_o = st_q.c;
    assign lo_o  = st_q.lo;

    logic [PW-1:0] acc_val, ref_val;
    assign acc_val = ((PW'(st_q.s) + PW'(st_q.c)) << (ROW + 1)) + PW'(st_q.lo & LOW_MASK);
    assign ref_val = PW'(st_q.a) * PW'(st_q.b & LOW_MASK);

    // R6
    csa_value_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> (acc_val == ref_val));

    if (ROW < WIDTH - 1) begin : g_hi_chk
        // R7
        lo_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.v |-> ((st_q.lo & ~LOW_MASK) == '0));
    end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_i,
    input  logic [WIDTH-1:0]   sum_i,
    input  logic [WIDTH-1:0]   cry_i,
    input  logic [WIDTH-1:0]   lo_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic               v_o,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int PROD_W = 2 * WIDTH;

    typedef struct packed {
        logic              v;
        logic [PROD_W-1:0] prod;
    } cpa_st_t;

    cpa_st_t st_d, st_q;
    logic [WIDTH-1:0] upper;

    // The product fits in PROD_W bits, so the carry out of this add is always zero.
    assign upper = sum_i + cry_i;

    always_comb begin
        st_d      = st_q;
        st_d.v    = v_i;
        st_d.prod = {upper, lo_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o    = st_q.v;
    assign prod_o = st_q.prod;

    // R1
    prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (prod_o == $past(PROD_W'(a_i) * PROD_W'(b_i))));
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] out_prod
);
    // Index r holds what enters row r; index WIDTH feeds the final adder.
    logic             v_w   [0:WIDTH];
    logic [WIDTH-1:0] a_w   [0:WIDTH];
    logic [WIDTH-1:0] b_w   [0:WIDTH];
    logic [WIDTH-1:0] s_w   [0:WIDTH];
    logic [WIDTH-1:0] c_w   [0:WIDTH];
    logic [WIDTH-1:0] lo_w  [0:WIDTH];

    assign v_w[0]  = in_valid;
    assign a_w[0]  = in_a;
    assign b_w[0]  = in_b;
    assign s_w[0]  = '0;
    assign c_w[0]  = '0;
    assign lo_w[0] = '0;

    for (genvar r = 0; r < WIDTH; r++) begin : g_row
        csa_row #(
            .WIDTH(WIDTH),
            .ROW  (r)
        ) u_row (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (v_w[r]),
            .a_i  (a_w[r]),
            .b_i  (b_w[r]),
            .sum_i(s_w[r]),
            .cry_i(c_w[r]),
            .lo_i (lo_w[r]),
            .v_o  (v_w[r+1]),
            .a_o  (a_w[r+1]),
            .b_o  (b_w[r+1]),
            .sum_o(s_w[r+1]),
            .cry_o(c_w[r+1]),
            .lo_o (lo_w[r+1])
        );
    end

    csa_cpa #(
        .WIDTH(WIDTH)
    ) u_cpa (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (v_w[WIDTH]),
        .sum_i (s_w[WIDTH]),
        .cry_i (c_w[WIDTH]),
        .lo_i  (lo_w[WIDTH]),
        .a_i   (a_w[WIDTH]),
        .b_i   (b_w[WIDTH]),
        .v_o   (out_valid),
        .prod_o(out_prod)
    );

    // R5
    rst_flush_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/csa_array_mult_tb.sv
module csa_array_mult_tb_top;
    localparam int W   = 8;
    localparam int LAT = W + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           out_valid;
    logic [2*W-1:0] out_prod;

    csa_array_mult #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_valid(out_valid),
        .out_prod (out_prod)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0;
    int    errors = 0;
    int    outs   = 0;
    int    sent   = 0;
    bit    finished = 1'b0;
    string ptag = "R4";

    logic [W-1:0] qa[$];
    logic [W-1:0] qb[$];
    int           qc[$];

    logic [W-1:0]   ea, eb;
    int             ec;
    logic [2*W-1:0] eprod;

    function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b);
        if (a == '1 && b == '1) return "R6";
        if ($countones(b) == 1) return "R7";
        return "R1";
    endfunction

    task automatic issue(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        if (v) begin
            qa.push_back(a);
            qb.push_back(b);
            qc.push_back(cyc);
            sent++;
        end
    endtask

    task automatic drain();
        for (int k = 0; k < LAT + 2; k++) issue(1'b0, W'($urandom), W'($urandom));
    endtask

    // Output monitor: order, value and latency of every result.
    always @(negedge clk) begin
        if (rst_n && !finished && out_valid) begin
            if (qa.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s: out_valid actual=1 expected=0 (no pair outstanding)", ptag);
            end else begin
                ea = qa.pop_front();
                eb = qb.pop_front();
                ec = qc.pop_front();
                eprod = (2*W)'(ea) * (2*W)'(eb);
                checks++;
                if (out_prod !== eprod) begin
                    errors++;
                    $display("FAIL %s: %0d*%0d actual=%0d expected=%0d",
                             tag_of(ea, eb), ea, eb, out_prod, eprod);
                end
                checks++;
                if (cyc - ec != LAT) begin
                    errors++;
                    $display("FAIL R2: latency actual=%0d expected=%0d", cyc - ec, LAT);
                end
                outs++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL R3: watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5: out_valid in reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;

        // R1 R3 R6 R7: every operand pair, back to back
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                issue(1'b1, W'(a), W'(b));
            end
        end
        drain();
        checks++;
        if (outs != sent || qa.size() != 0) begin
            errors++;
            $display("FAIL R3: results actual=%0d expected=%0d", outs, sent);
        end

        // R4: random gaps with junk operands in the gaps
        for (int k = 0; k < 3000; k++) begin
            issue(1'($urandom_range(0, 1)), W'($urandom), W'($urandom));
        end
        drain();
        checks++;
        if (outs != sent || qa.size() != 0) begin
            errors++;
            $display("FAIL R4: results actual=%0d expected=%0d", outs, sent);
        end

        // R5: reset with pairs in flight
        for (int k = 0; k < 5; k++) issue(1'b1, W'(k + 3), W'(200 - k));
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        sent    -= qa.size();
        qa.delete(); qb.delete(); qc.delete();
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5: out_valid after reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        ptag  = "R5";
        drain();
        ptag  = "R4";

        // R6 R7 after reset: carry-heavy and single-bit multipliers
        issue(1'b1, '1, '1);
        for (int k = 0; k < W; k++) issue(1'b1, 8'hA7, W'(1) << k);
        drain();
        checks++;
        if (outs != sent || qa.size() != 0) begin
            errors++;
            $display("FAIL R3: results after reset actual=%0d expected=%0d", outs, sent);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule